// File: doc/BRIEF.md
# Multi-Source Interrupt Request Aggregator

This block merges a group of peripheral event lines into a single maskable interrupt request for a CPU interrupt controller. Every source owns a sticky status flag, which a one-cycle hardware pulse sets and only software clears, plus an enable bit that software writes. The request bit is a live level: it is high exactly while some source has both its flag and its enable set. It is never latched, never cleared by acknowledge and never written by software. Clearing the flags in the handler is the only way to retire it.

The request is then gated for delivery to the CPU. Delivery needs the global interrupt-enable flag to be set, and the 3-bit priority held in the control register must be strictly above the processor's current priority level. A priority of zero therefore silences the source. Software reads the status register to find out which sources are pending.

A small register port gives access to the block. The status register is at address 0, the enable register at address 1, and the control register at address 2. The control register holds the priority in bits [2:0] and a read-only copy of the request in bit 3. Reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: `int_request` is 1 in the cycle after any edge that leaves at least one source with both its status bit and its enable bit at 1.
- R2: `int_request` returns to 0 in the first cycle in which no source has both bits at 1. It keeps no pending state, whether or not an acknowledge was ever given.
- R3: A write to the control register (address 2) stores bits [2:0] as the priority and ignores bit 3. `int_request` and read bit 3 still follow the status and enable registers.
- R4: Pulsing `int_ack` leaves the status register, the enable register and `int_request` unchanged.
- R5: While `int_request` is 1, further events on other sources keep it at 1 with no gap cycle.
- R6: The status register reads back at address 0 with bit i showing source i. Writing 0 to bit i clears it, and writing 1 leaves it unchanged.
- R7: An event on source i in the same cycle as a software clear of bit i leaves bit i set.
- R8: `int_to_cpu` equals `glob_ie` AND `int_request` AND (priority > `cpu_level`), using unsigned compare. `int_level` shows the stored priority. A priority of 0 never forwards.
- R9: After reset the status register, the enable register and the priority are 0, and `int_request` and `int_to_cpu` are 0.
- R10: Address 1 reads and writes the enable register. Address 2 reads {zeros, request, priority[2:0]}. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| write_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| write_data | input | N_SRC (8) | Write data |
| read_data | output | N_SRC (8) | Combinational read data for `reg_addr` |
| event_pulse | input | N_SRC (8) | Per-source set pulses |
| int_ack | input | 1 | Interrupt acknowledge from the CPU (clears nothing) |
| glob_ie | input | 1 | Global interrupt-enable flag |
| cpu_level | input | 3 | Current processor priority level |
| int_request | output | 1 | Live request level |
| int_to_cpu | output | 1 | Request forwarded to the CPU after gating |
| int_level | output | 3 | Stored priority level |

## Verification
The hardest case to reach from the ports is a software clear and a hardware event hitting the same status bit on the same edge. A second hard case is a request that must stay high with no gap while one source is cleared and another arrives. Directed steps line these up cycle by cycle: they issue a clear-by-zero write together with a pulse on the same bit, and they retire one source while a new one is raised. The random phase then writes status masks with many zero bits while events fire densely. This makes same-cycle collisions and request hand-overs between sources occur often, and each cycle is checked against a bench model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_CTRL   = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;

  // forwarding rule: global flag, live request, strictly higher priority
  function automatic logic f_forward(input logic gie, input logic req,
                                     input logic [PRIO_W-1:0] prio,
                                     input logic [PRIO_W-1:0] ipl);
    return gie && req && (prio > ipl);
  endfunction

  // next status flag: a set pulse outranks a clear on the same edge
  function automatic logic f_flag_next(input logic cur, input logic set,
                                       input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] flag_q;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[gi] <= 1'b0;
      else        flag_q[gi] <= f_flag_next(flag_q[gi], set_i[gi], clr_i[gi]);
    end
  end

  assign status_o = flag_q;

  // set pulse always lands, even against a clear
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & flag_q) == $past(set_i))); // R7
  // a flag only rises from a pulse
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0)); // R6
  // a flag only falls from a clear
  AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr_i)) == '0)); // R6
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr_i,
  input  logic              prio_wr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  enable_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic [N_SRC-1:0]  enable_q;
  logic [PRIO_W-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      prio_q   <= '0;
    end else begin
      if (en_wr_i)   enable_q <= wdata_i;
      if (prio_wr_i) prio_q   <= wdata_i[PRIO_W-1:0];
    end
  end

  assign enable_o = enable_q;
  assign prio_o   = prio_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i && !prio_wr_i |=> $stable(enable_q) && $stable(prio_q)); // R4
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  status_i,
  input  logic [N_SRC-1:0]  enable_i,
  input  logic              gie_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] ipl_i,
  output logic              req_o,
  output logic              fwd_o
);
  logic [N_SRC-1:0] hit_vec;

  assign hit_vec = status_i & enable_i;
  assign req_o   = |hit_vec;
  assign fwd_o   = f_forward(gie_i, req_o, prio_i, ipl_i);

  AST_PRIO0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_i == '0) |-> !fwd_o); // R8
  AST_FWD_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !fwd_o); // R8
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              write_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_SRC-1:0]  write_data,
  output logic [N_SRC-1:0]  read_data,
  input  logic [N_SRC-1:0]  event_pulse,
  input  logic              int_ack,
  input  logic              glob_ie,
  input  logic [PRIO_W-1:0] cpu_level,
  output logic              int_request,
  output logic              int_to_cpu,
  output logic [PRIO_W-1:0] int_level
);
  localparam int unsigned REQ_BIT = PRIO_W;

  logic [N_SRC-1:0]  status_w;
  logic [N_SRC-1:0]  enable_w;
  logic [PRIO_W-1:0] prio_w;
  logic [N_SRC-1:0]  clr_mask;
  logic              wr_status, wr_enable, wr_ctrl;
  logic              req_w, fwd_w;

  assign wr_status = write_en && (reg_addr == A_STATUS);
  assign wr_enable = write_en && (reg_addr == A_ENABLE);
  assign wr_ctrl   = write_en && (reg_addr == A_CTRL);
  assign clr_mask  = wr_status ? ~write_data : '0;

  irq_status_bank #(.N_SRC(N_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(event_pulse), .clr_i(clr_mask),
    .status_o(status_w));

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en_wr_i(wr_enable), .prio_wr_i(wr_ctrl),
    .wdata_i(write_data), .enable_o(enable_w), .prio_o(prio_w));

  irq_req_gate #(.N_SRC(N_SRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .status_i(status_w), .enable_i(enable_w),
    .gie_i(glob_ie), .prio_i(prio_w), .ipl_i(cpu_level),
    .req_o(req_w), .fwd_o(fwd_w));

  always_comb begin
    read_data = '0;
    case (reg_addr)
      A_STATUS: read_data = status_w;
      A_ENABLE: read_data = enable_w;
      A_CTRL: begin
        read_data[PRIO_W-1:0] = prio_w;
        read_data[REQ_BIT]    = req_w;
      end
      default: read_data = '0;
    endcase
  end

  assign int_request = req_w;
  assign int_to_cpu  = fwd_w;
  assign int_level   = prio_w;

  // acknowledge alone touches no state
  AST_ACK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !write_en && (event_pulse == '0)
      |=> $stable(status_w) && $stable(enable_w) && $stable(int_request)); // R4
  // request falls only because a status or enable bit fell
  AST_REQ_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_request) |-> (status_w != $past(status_w)) || (enable_w != $past(enable_w))); // R2
  // a raised event on an enabled source keeps the request up
  AST_REQ_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_pulse & enable_w) != '0) && !wr_enable |=> int_request); // R5
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic write_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [N-1:0] write_data = '0;
  logic [N-1:0] read_data;
  logic [N-1:0] event_pulse = '0;
  logic int_ack = 1'b0;
  logic glob_ie = 1'b0;
  logic [2:0] cpu_level = 3'd0;
  logic int_request, int_to_cpu;
  logic [2:0] int_level;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] m_st = '0, m_en = '0;
  logic [2:0] m_pr = '0;

  always #2 clk = ~clk;

  irq_aggregator #(.N_SRC(N)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .write_en(write_en), .reg_addr(reg_addr),
    .write_data(write_data), .read_data(read_data), .event_pulse(event_pulse),
    .int_ack(int_ack), .glob_ie(glob_ie), .cpu_level(cpu_level),
    .int_request(int_request), .int_to_cpu(int_to_cpu), .int_level(int_level));

  function automatic logic exp_req();
    return (m_st & m_en) != '0;
  endfunction

  function automatic logic exp_fwd();
    return glob_ie && exp_req() && (m_pr > cpu_level);
  endfunction

  function automatic logic [N-1:0] exp_rd(input logic [1:0] a);
    logic [N-1:0] v;
    v = '0;
    case (a)
      2'd0: v = m_st;
      2'd1: v = m_en;
      2'd2: begin v[2:0] = m_pr; v[3] = exp_req(); end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R1/R2 int_request"}, 32'(int_request), 32'(exp_req()));
    chk({tag, " R8 int_to_cpu"}, 32'(int_to_cpu), 32'(exp_fwd()));
    chk({tag, " R8 int_level"}, 32'(int_level), 32'(m_pr));
    chk({tag, " R10 read_data"}, 32'(read_data), 32'(exp_rd(reg_addr)));
  endtask

  // one cycle: drive at negedge, update model at posedge, check just after
  task automatic step(input logic wr, input logic [1:0] a, input logic [N-1:0] d,
                      input logic [N-1:0] ev, input logic ak, input string tag);
    @(negedge clk);
    write_en = wr; reg_addr = a; write_data = d; event_pulse = ev; int_ack = ak;
    @(posedge clk);
    if (wr && a == 2'd0) m_st = m_st & d;
    m_st = m_st | ev;
    if (wr && a == 2'd1) m_en = d;
    if (wr && a == 2'd2) m_pr = d[2:0];
    #1;
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] pre_st;
    int unused_seed;
    unused_seed = $urandom(32'h1234_5678);
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 reset request", 32'(int_request), 32'd0);
    chk("R9 reset to_cpu", 32'(int_to_cpu), 32'd0);
    chk("R9 reset status read", 32'(read_data), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 2'd1, '0, '0, 0, "R9 enable after reset");
    step(0, 2'd2, '0, '0, 0, "R9 ctrl after reset");
    // R1: enable sources 0 and 3, fire source 3
    step(1, 2'd1, 8'h09, '0, 0, "R10 enable write");
    step(0, 2'd2, '0, 8'h08, 0, "R1 event raises request");
    chk("R1 request high", 32'(int_request), 32'd1);
    // R5: another source while already requesting
    step(0, 2'd0, '0, 8'h01, 0, "R5 second event");
    chk("R5 still high", 32'(int_request), 32'd1);
    // R4: acknowledge clears nothing
    step(0, 2'd0, '0, '0, 1, "R4 ack");
    chk("R4 status kept", 32'(read_data), 32'h09);
    chk("R4 request kept", 32'(int_request), 32'd1);
    // R3: writing 0 to request bit has no effect, prio stored
    step(1, 2'd2, 8'h05, '0, 0, "R3 ctrl write req=0");
    chk("R3 request unaffected", 32'(int_request), 32'd1);
    chk("R3 ctrl readback", 32'(read_data), 32'h0D);
    // R8 forwarding rule
    glob_ie = 1'b1; cpu_level = 3'd4;
    step(0, 2'd2, '0, '0, 0, "R8 prio above level");
    chk("R8 forwarded", 32'(int_to_cpu), 32'd1);
    cpu_level = 3'd5;
    step(0, 2'd2, '0, '0, 0, "R8 prio equal level");
    chk("R8 equal blocks", 32'(int_to_cpu), 32'd0);
    cpu_level = 3'd0;
    step(1, 2'd2, 8'h08, '0, 0, "R8 prio zero with bit3 set");
    chk("R8 prio zero silent", 32'(int_to_cpu), 32'd0);
    chk("R3 bit3 write ignored", 32'(read_data), 32'h08);
    step(1, 2'd2, 8'h07, '0, 0, "R8 prio 7");
    glob_ie = 1'b0;
    step(0, 2'd2, '0, '0, 0, "R8 gie off");
    chk("R8 gie blocks", 32'(int_to_cpu), 32'd0);
    glob_ie = 1'b1;
    // R6/R5: clear source 3 (writing 1s elsewhere keeps them), request stays
    step(1, 2'd0, 8'hF7, '0, 0, "R6 clear bit3");
    chk("R6 status after clear", 32'(read_data), 32'h01);
    chk("R5 request no gap", 32'(int_request), 32'd1);
    // R2: clear last enabled source, request falls at once
    step(1, 2'd0, 8'hFE, '0, 0, "R2 clear last");
    chk("R2 request dropped", 32'(int_request), 32'd0);
    // R7: same-cycle set and clear on bit 2
    step(0, 2'd0, '0, 8'h04, 0, "R7 prep");
    step(1, 2'd0, 8'h00, 8'h04, 0, "R7 collide");
    chk("R7 set wins", 32'(read_data), 32'h04);
    // R2: status set but enable 0 -> no request
    chk("R2 disabled source", 32'(int_request), 32'd0);
    step(1, 2'd1, 8'h04, '0, 0, "R1 enable later");
    chk("R1 late enable raises", 32'(int_request), 32'd1);
    step(1, 2'd1, 8'h00, '0, 0, "R2 disable drops");
    chk("R2 disable drops request", 32'(int_request), 32'd0);
    // R10: spare address
    step(1, 2'd3, 8'hFF, '0, 0, "R10 spare write");
    chk("R10 spare reads 0", 32'(read_data), 32'd0);
    step(0, 2'd1, '0, '0, 0, "R10 enable untouched by spare");
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic wr, ak;
      logic [1:0] a;
      logic [N-1:0] d, ev;
      wr = ($urandom % 3) == 0;
      a = 2'($urandom);
      d = N'($urandom) & N'($urandom);
      ev = (N'($urandom) & N'($urandom) & N'($urandom));
      ak = 1'($urandom);
      glob_ie = ($urandom % 4) != 0;
      cpu_level = 3'($urandom);
      pre_st = m_st;
      step(wr, a, d, ev, ak, "R6 R7 random");
      if (ak && !wr && ev == '0)
        chk("R4 random ack", 32'(m_st == pre_st), 32'd1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule